// File: doc/BRIEF.md
# TDM Slot-Masked Serial Receiver

This block is the receive half of a synchronous serial port for time-division multiplexed links. It takes edge strobes for the serial bit clock, plus slot-start and frame-start strobes, from an external timing generator running in the system clock domain. It samples the serial data input on the chosen clock edge, builds one word per time slot with a programmable length and bit order, and places each finished word into a 24-bit holding register. Short words are placed at a selectable alignment. For 32-bit words, 24 of the 32 bits are kept.

A 32-bit per-slot mask picks which slots the host receives. A word that lands in a masked slot is dropped without any sign: no data, no full flag and no overrun. If a word arrives while the holding register still has an unread word, the old word is kept, the new word is thrown away, and an overrun flag is raised. The host clears that flag by reading status and then data. The receiver can follow the transmitter's strobes (synchronous mode) or its own set of strobes (asynchronous mode).

Top module: `tdm_slot_rx`

## Requirements
- R1: `wl_i` sets the word length: 000=8, 001=12, 010=16, 011=24, 100=32 keeping value bits [31:8], 101=32 keeping value bits [23:0], 110/111 behave as 24. Here "value" is the word with the first received bit as its most significant bit when MSB-first.
- R2: With `align15_i`=0, an 8/12/16-bit word lands in `data_o[23:24-L]`. With 1, it lands in `data_o[15:16-L]`. All other bits are 0. Alignment has no effect on 24- and 32-bit words.
- R3: With `lsb_first_i`=0 the first received bit is the word MSB. With 1 it is the word LSB.
- R4: A word starts on a sample strobe that comes with a slot or frame strobe. Two clock cycles after the sample of its last bit, the word is in `data_o` and `full_o` is 1. A `data_rd_i` pulse clears `full_o`.
- R5: A word that completes in an unmasked slot while `full_o`=1 sets `overrun_o`, and `data_o` keeps the old word.
- R6: `overrun_o` is cleared only by a `data_rd_i` that comes after a `stat_rd_i` seen while the flag was set. A data read on its own leaves the flag set.
- R7: The slot index becomes 0 on a frame strobe and goes up by one on each slot strobe. When `slot_mask_i[index]`=0, a word completing in that slot changes neither `data_o`, `full_o` nor `overrun_o`.
- R8: With `sync_mode_i`=1 only the `tx_*` strobes are used. With 0 only the `rx_*` strobes are used.
- R9: With `ckp_i`=0 data is sampled on the falling-edge strobe. With 1 it is sampled on the rising-edge strobe. The other edge strobe is ignored.
- R10: After reset, `data_o`=0, `full_o`=0 and `overrun_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sync_mode_i | input | 1 | 1: use the transmitter's strobes, 0: use the receiver's own |
| ckp_i | input | 1 | Sample edge: 0 falling, 1 rising |
| tx_rise_i | input | 1 | Transmit bit clock rising-edge strobe |
| tx_fall_i | input | 1 | Transmit bit clock falling-edge strobe |
| tx_slot_i | input | 1 | Transmit slot start, qualified by the sample strobe |
| tx_frame_i | input | 1 | Transmit frame start, qualified by the sample strobe |
| rx_rise_i | input | 1 | Receive bit clock rising-edge strobe |
| rx_fall_i | input | 1 | Receive bit clock falling-edge strobe |
| rx_slot_i | input | 1 | Receive slot start |
| rx_frame_i | input | 1 | Receive frame start |
| sdata_i | input | 1 | Serial data |
| wl_i | input | 3 | Word length code |
| align15_i | input | 1 | Short-word alignment select |
| lsb_first_i | input | 1 | Bit order select |
| slot_mask_i | input | 32 | Per-slot receive enable |
| data_rd_i | input | 1 | Host read of the holding register |
| stat_rd_i | input | 1 | Host read of status |
| data_o | output | 24 | Holding register |
| full_o | output | 1 | Holding register has an unread word |
| overrun_o | output | 1 | A word was lost to an unread holding register |

## Verification
The assertions assume that a slot is at least eight sample strobes long. They also assume that `wl_i`, `align15_i` and `lsb_first_i` stay constant while a word is being assembled. Under these assumptions a completion pulse never lasts two cycles, and the bit counter stays within 32. The stimulus changes format settings only between words, with the strobes idle. It sends every word as a full run of sample strobes spaced two system cycles apart. Host reads are single-cycle pulses that never coincide with a completion, so the flag assertions only see orderings that the requirements define.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;
  localparam int WORD_W = 32;
  localparam int DATA_W = 24;
  localparam int SLOTS  = 32;
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int CNT_W  = $clog2(WORD_W + 1);

  typedef enum logic [2:0] {
    WL_8       = 3'b000,
    WL_12      = 3'b001,
    WL_16      = 3'b010,
    WL_24      = 3'b011,
    WL_32_HEAD = 3'b100,
    WL_32_TAIL = 3'b101,
    WL_RSV6    = 3'b110,
    WL_RSV7    = 3'b111
  } wl_code_e;

  function automatic logic [CNT_W-1:0] wl_bits(input logic [2:0] code);
    case (wl_code_e'(code))
      WL_8:       wl_bits = CNT_W'(8);
      WL_12:      wl_bits = CNT_W'(12);
      WL_16:      wl_bits = CNT_W'(16);
      WL_32_HEAD: wl_bits = CNT_W'(32);
      WL_32_TAIL: wl_bits = CNT_W'(32);
      default:    wl_bits = CNT_W'(24);
    endcase
  endfunction

  // right-justified word -> holding register layout
  function automatic logic [DATA_W-1:0] align_word(input logic [WORD_W-1:0] w,
                                                   input logic [2:0] code,
                                                   input logic a15);
    case (wl_code_e'(code))
      WL_8:       align_word = a15 ? {8'h00, w[7:0], 8'h00}  : {w[7:0], 16'h0000};
      WL_12:      align_word = a15 ? {8'h00, w[11:0], 4'h0}  : {w[11:0], 12'h000};
      WL_16:      align_word = a15 ? {8'h00, w[15:0]}        : {w[15:0], 8'h00};
      WL_32_HEAD: align_word = w[31:8];
      default:    align_word = w[23:0];
    endcase
  endfunction
endpackage

// File: rtl/rx_strobe_sel.sv
module rx_strobe_sel (
  input  logic sync_mode_i,
  input  logic ckp_i,
  input  logic tx_rise_i,
  input  logic tx_fall_i,
  input  logic tx_slot_i,
  input  logic tx_frame_i,
  input  logic rx_rise_i,
  input  logic rx_fall_i,
  input  logic rx_slot_i,
  input  logic rx_frame_i,
  output logic sample_o,
  output logic slot_o,
  output logic frame_o
);
  logic rise_s, fall_s;

  always_comb begin
    rise_s   = sync_mode_i ? tx_rise_i  : rx_rise_i;
    fall_s   = sync_mode_i ? tx_fall_i  : rx_fall_i;
    slot_o   = sync_mode_i ? tx_slot_i  : rx_slot_i;
    frame_o  = sync_mode_i ? tx_frame_i : rx_frame_i;
    // capture on the edge opposite the launch edge
    sample_o = ckp_i ? rise_s : fall_s;
  end
endmodule

// File: rtl/rx_word_shifter.sv
module rx_word_shifter
  import tdm_rx_pkg::*;
#(
  parameter int W_W  = WORD_W,
  parameter int S_W  = SLOT_W,
  localparam int C_W = $clog2(W_W + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           sample_i,
  input  logic           slot_i,
  input  logic           frame_i,
  input  logic           bit_i,
  input  logic [2:0]     wl_i,
  input  logic           lsb_first_i,
  output logic           done_o,
  output logic [W_W-1:0] word_o,
  output logic [S_W-1:0] slot_idx_o
);
  logic [W_W-1:0] shreg_q, shreg_n, base_s, word_q;
  logic [C_W-1:0] cnt_q, cnt_n, len_s;
  logic [S_W-1:0] idx_q, idx_n, done_idx_q;
  logic           active_q, done_q;
  logic           start_s, take_s, last_s;

  always_comb begin
    len_s   = C_W'(wl_bits(wl_i));
    start_s = sample_i & (slot_i | frame_i);
    take_s  = sample_i & (start_s | active_q);
    base_s  = start_s ? '0 : shreg_q;
    shreg_n = lsb_first_i ? {bit_i, base_s[W_W-1:1]} : {base_s[W_W-2:0], bit_i};
    cnt_n   = start_s ? C_W'(1) : cnt_q + C_W'(1);
    idx_n   = frame_i ? '0 : idx_q + S_W'(1);
    last_s  = take_s && (cnt_n == len_s);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q    <= '0;
      cnt_q      <= '0;
      active_q   <= 1'b0;
      idx_q      <= '0;
      done_q     <= 1'b0;
      word_q     <= '0;
      done_idx_q <= '0;
    end else begin
      done_q <= last_s;
      if (take_s) begin
        shreg_q  <= shreg_n;
        cnt_q    <= cnt_n;
        active_q <= !last_s;
      end
      if (start_s) idx_q <= idx_n;
      if (last_s) begin
        word_q     <= lsb_first_i ? (shreg_n >> (W_W - int'(len_s))) : shreg_n;
        done_idx_q <= start_s ? idx_n : idx_q;
      end
    end
  end

  assign done_o     = done_q;
  assign word_o     = word_q;
  assign slot_idx_o = done_idx_q;

  // R1
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  // R1
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= C_W'(W_W));
endmodule

// File: rtl/rx_hold_reg.sv
module rx_hold_reg
  import tdm_rx_pkg::*;
#(
  parameter int W_W   = WORD_W,
  parameter int D_W   = DATA_W,
  parameter int N_SL  = SLOTS,
  localparam int S_W  = $clog2(N_SL)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            done_i,
  input  logic [W_W-1:0]  word_i,
  input  logic [S_W-1:0]  slot_idx_i,
  input  logic [N_SL-1:0] slot_mask_i,
  input  logic [2:0]      wl_i,
  input  logic            align15_i,
  input  logic            data_rd_i,
  input  logic            stat_rd_i,
  output logic [D_W-1:0]  data_o,
  output logic            full_o,
  output logic            overrun_o
);
  logic [D_W-1:0] data_q;
  logic           full_q, ovr_q, armed_q;
  logic           accept_s, full_eff_s;

  always_comb begin
    accept_s   = done_i & slot_mask_i[slot_idx_i];
    full_eff_s = full_q & ~data_rd_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      full_q  <= 1'b0;
      ovr_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (accept_s && !full_eff_s) begin
        data_q <= D_W'(align_word(word_i, wl_i, align15_i));
        full_q <= 1'b1;
      end else if (data_rd_i) begin
        full_q <= 1'b0;
      end
      if (accept_s && full_eff_s) begin
        ovr_q   <= 1'b1;
        armed_q <= 1'b0;
      end else if (ovr_q && armed_q && data_rd_i) begin
        ovr_q   <= 1'b0;
        armed_q <= 1'b0;
      end else if (ovr_q && stat_rd_i) begin
        armed_q <= 1'b1;
      end
    end
  end

  assign data_o    = data_q;
  assign full_o    = full_q;
  assign overrun_o = ovr_q;

  // R4
  full_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(full_q) |-> $past(done_i));
  // R7
  masked_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !slot_mask_i[slot_idx_i]) |=> ($stable(ovr_q) && $stable(data_q)));
  // R5
  keep_old_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_q && !data_rd_i) |=> $stable(data_q));
  // R5
  ovr_needs_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_q) |-> $past(full_q));
  // R6
  ovr_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ovr_q) |-> $past(data_rd_i));
endmodule

// File: rtl/tdm_slot_rx.sv
module tdm_slot_rx
  import tdm_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sync_mode_i,
  input  logic              ckp_i,
  input  logic              tx_rise_i,
  input  logic              tx_fall_i,
  input  logic              tx_slot_i,
  input  logic              tx_frame_i,
  input  logic              rx_rise_i,
  input  logic              rx_fall_i,
  input  logic              rx_slot_i,
  input  logic              rx_frame_i,
  input  logic              sdata_i,
  input  logic [2:0]        wl_i,
  input  logic              align15_i,
  input  logic              lsb_first_i,
  input  logic [SLOTS-1:0]  slot_mask_i,
  input  logic              data_rd_i,
  input  logic              stat_rd_i,
  output logic [DATA_W-1:0] data_o,
  output logic              full_o,
  output logic              overrun_o
);
  logic              sample_s, slot_s, frame_s, done_s;
  logic [WORD_W-1:0] word_s;
  logic [SLOT_W-1:0] idx_s;

  rx_strobe_sel u_sel (
    .sync_mode_i, .ckp_i,
    .tx_rise_i, .tx_fall_i, .tx_slot_i, .tx_frame_i,
    .rx_rise_i, .rx_fall_i, .rx_slot_i, .rx_frame_i,
    .sample_o (sample_s),
    .slot_o   (slot_s),
    .frame_o  (frame_s)
  );

  rx_word_shifter #(.W_W(WORD_W), .S_W(SLOT_W)) u_shift (
    .clk_i, .rst_ni,
    .sample_i    (sample_s),
    .slot_i      (slot_s),
    .frame_i     (frame_s),
    .bit_i       (sdata_i),
    .wl_i, .lsb_first_i,
    .done_o      (done_s),
    .word_o      (word_s),
    .slot_idx_o  (idx_s)
  );

  rx_hold_reg #(.W_W(WORD_W), .D_W(DATA_W), .N_SL(SLOTS)) u_hold (
    .clk_i, .rst_ni,
    .done_i      (done_s),
    .word_i      (word_s),
    .slot_idx_i  (idx_s),
    .slot_mask_i, .wl_i, .align15_i, .data_rd_i, .stat_rd_i,
    .data_o, .full_o, .overrun_o
  );
endmodule

// File: tb/tdm_slot_rx_tb_top.sv
module tdm_slot_rx_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sync_mode = 1'b1, ckp = 1'b0;
  logic tx_rise = 0, tx_fall = 0, tx_slot = 0, tx_frame = 0;
  logic rx_rise = 0, rx_fall = 0, rx_slot = 0, rx_frame = 0;
  logic sdata = 0, align15 = 0, lsb_first = 0, data_rd = 0, stat_rd = 0;
  logic [2:0]  wl = 3'b000;
  logic [31:0] mask = '1;
  logic [23:0] data;
  logic full, overrun;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  tdm_slot_rx dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sync_mode_i(sync_mode), .ckp_i(ckp),
    .tx_rise_i(tx_rise), .tx_fall_i(tx_fall), .tx_slot_i(tx_slot), .tx_frame_i(tx_frame),
    .rx_rise_i(rx_rise), .rx_fall_i(rx_fall), .rx_slot_i(rx_slot), .rx_frame_i(rx_frame),
    .sdata_i(sdata), .wl_i(wl), .align15_i(align15), .lsb_first_i(lsb_first),
    .slot_mask_i(mask), .data_rd_i(data_rd), .stat_rd_i(stat_rd),
    .data_o(data), .full_o(full), .overrun_o(overrun)
  );

  // {wl, align15, lsb_first, value, expected data}
  localparam logic [60:0] VEC [8] = '{
    {3'b000, 1'b0, 1'b0, 32'h000000A5, 24'hA50000},
    {3'b001, 1'b1, 1'b0, 32'h00000ABC, 24'h00ABC0},
    {3'b010, 1'b0, 1'b1, 32'h00001234, 24'h123400},
    {3'b011, 1'b1, 1'b0, 32'h0089ABCD, 24'h89ABCD},
    {3'b100, 1'b0, 1'b0, 32'hDEADBEEF, 24'hDEADBE},
    {3'b101, 1'b0, 1'b0, 32'hDEADBEEF, 24'hADBEEF},
    {3'b000, 1'b1, 1'b1, 32'h0000003C, 24'h003C00},
    {3'b101, 1'b1, 1'b1, 32'h12345678, 24'h345678}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int len_of(input logic [2:0] c);
    case (c)
      3'b000: return 8;
      3'b001: return 12;
      3'b010: return 16;
      3'b100, 3'b101: return 32;
      default: return 24;
    endcase
  endfunction

  // which: 0 tx_fall, 1 tx_rise, 2 rx_fall, 3 rx_rise
  task automatic send(input logic [31:0] v, input int len, input logic lsb,
                      input bit frm, input int which);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      sdata = lsb ? v[i] : v[len-1-i];
      tx_fall = (which == 0); tx_rise = (which == 1);
      rx_fall = (which == 2); rx_rise = (which == 3);
      tx_slot = (i == 0); rx_slot = (i == 0);
      tx_frame = frm && (i == 0); rx_frame = frm && (i == 0);
      @(negedge clk);
      {tx_fall, tx_rise, rx_fall, rx_rise, tx_slot, rx_slot, tx_frame, rx_frame} = '0;
    end
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_rd();
    @(negedge clk); data_rd = 1'b1;
    @(negedge clk); data_rd = 1'b0;
  endtask

  task automatic pulse_stat();
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 data", 32'(data), 0);
    chk("R10 full", 32'(full), 0);
    chk("R10 overrun", 32'(overrun), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R3 R4: format table
    foreach (VEC[k]) begin
      wl = VEC[k][60:58]; align15 = VEC[k][57]; lsb_first = VEC[k][56];
      send(VEC[k][55:24], len_of(wl), lsb_first, 1'b1, 0);
      chk($sformatf("R1 R2 R3 vec%0d data", k), 32'(data), 32'(VEC[k][23:0]));
      chk($sformatf("R4 vec%0d full", k), 32'(full), 1);
      pulse_rd();
      chk($sformatf("R4 vec%0d read clears", k), 32'(full), 0);
    end

    // R7 slot masking
    wl = 3'b000; align15 = 0; lsb_first = 0; mask = 32'h5;
    send(32'h11, 8, 0, 1'b1, 0);
    chk("R7 slot0 data", 32'(data), 32'h110000);
    pulse_rd();
    send(32'h22, 8, 0, 1'b0, 0);
    chk("R7 slot1 masked full", 32'(full), 0);
    chk("R7 slot1 masked data", 32'(data), 32'h110000);
    send(32'h33, 8, 0, 1'b0, 0);
    chk("R7 slot2 data", 32'(data), 32'h330000);
    chk("R7 slot2 full", 32'(full), 1);
    pulse_rd();

    // R5 R6 overrun
    send(32'h44, 8, 0, 1'b1, 0);
    send(32'h55, 8, 0, 1'b1, 0);
    chk("R5 overrun set", 32'(overrun), 1);
    chk("R5 old data kept", 32'(data), 32'h440000);
    pulse_rd();
    chk("R6 data read alone", 32'(overrun), 1);
    chk("R4 full cleared", 32'(full), 0);
    pulse_stat();
    chk("R6 status read alone", 32'(overrun), 1);
    pulse_rd();
    chk("R6 cleared", 32'(overrun), 0);

    // R7 masked slot while full: no overrun
    send(32'h66, 8, 0, 1'b1, 0);
    send(32'h77, 8, 0, 1'b0, 0);
    chk("R7 masked no overrun", 32'(overrun), 0);
    chk("R7 masked keeps data", 32'(data), 32'h660000);
    pulse_rd();

    // R9 clock polarity
    send(32'h99, 8, 0, 1'b1, 1);
    chk("R9 rise ignored ckp0", 32'(full), 0);
    ckp = 1'b1;
    send(32'h5A, 8, 0, 1'b1, 1);
    chk("R9 rise used ckp1", 32'(data), 32'h5A0000);
    pulse_rd();

    // R8 async uses rx strobes only
    sync_mode = 1'b0;
    send(32'h12, 8, 0, 1'b1, 1);
    chk("R8 tx ignored async", 32'(full), 0);
    send(32'h34, 8, 0, 1'b1, 3);
    chk("R8 rx used async", 32'(data), 32'h340000);
    chk("R8 rx full", 32'(full), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule